// File: doc/BRIEF.md
# CAN Sleep Entry and Wake Controller

This block decides when the protocol side of a CAN controller may drop into its low-power state, and it reports that decision back to software. Software sets a sleep request bit in the bus (register) clock domain. The request crosses into the CAN clock domain through a flop chain. There it does not act at once: any transmit buffer still marked full, or a frame being sent, holds off sleep until all buffers report empty. A frame being received holds off sleep until the protocol engine next reports the bus idle. When nothing is in flight, sleep starts on the first CAN clock edge after the request has crossed.

While asleep, the block drops the clock enable of the protocol logic and forces the transmit pin recessive. It blocks the receive FIFO from loading a new foreground message and blocks transmit aborts. It also freezes the bus-off recovery counter, which counts runs of recessive bits. The protocol state crosses back to the bus domain and becomes the acknowledge bit. Sleep is in force only while request and acknowledge both read 1. When software clears the request, the clock enable returns, and the acknowledge falls once the wake state has crossed back.

Top module: `can_sleep_ctrl`

## Requirements
- R1: After reset, sleep_ack is 0, can_clk_en is 1, both inhibit outputs are 0, tx_pin equals tx_core and busoff_runs is 0.
- R2: With every txe bit 1 and tx_busy, rx_busy both 0, setting sleep_req makes can_clk_en 0 and then sleep_ack 1, within 10 bus clock cycles of the request and no sooner than 3.
- R3: While any txe bit is 0 or tx_busy is 1, sleep is not entered; once all txe bits are 1 and tx_busy is 0 with the request still held, sleep is entered.
- R4: If rx_busy is 1 after the request arrives, sleep waits for a bus_idle pulse, even if rx_busy falls first. It is entered on that pulse when no transmit work is pending.
- R5: While asleep (can_clk_en 0), tx_pin is 1 regardless of tx_core, and rx_shift_inhibit and abort_inhibit are both 1.
- R6: busoff_runs counts run11 pulses while bus_off is 1 and the block is awake. It saturates at RECOV_RUNS (128), with busoff_done 1 there. It holds its value while asleep and returns to 0 when bus_off is 0.
- R7: Clearing sleep_req restores can_clk_en to 1 and then returns sleep_ack to 0, and tx_pin follows tx_core again.
- R8: Clearing sleep_req while entry is still deferred cancels it: sleep is not entered even when the pending work later finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-side clock |
| can_clk | input | 1 | Protocol-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| sleep_req | input | 1 | Software sleep request (bus domain) |
| sleep_ack | output | 1 | Sleep acknowledge (bus domain) |
| txe | input | NUM_TXB | Transmit buffer empty flags, 1 = empty (CAN domain) |
| tx_busy | input | 1 | Protocol engine is sending a frame |
| rx_busy | input | 1 | Protocol engine is receiving a frame |
| bus_idle | input | 1 | One-cycle pulse: 11 recessive bits sampled |
| bus_off | input | 1 | Controller is in bus-off state |
| run11 | input | 1 | One-cycle pulse per run of 11 recessive bits |
| tx_core | input | 1 | Transmit bit from the protocol engine |
| tx_pin | output | 1 | Transmit pin value, recessive = 1 |
| can_clk_en | output | 1 | Clock enable for protocol logic |
| rx_shift_inhibit | output | 1 | Blocks load of the receive foreground buffer |
| abort_inhibit | output | 1 | Blocks transmit aborts |
| busoff_runs | output | CNT_W | Bus-off recovery run count |
| busoff_done | output | 1 | Recovery count reached RECOV_RUNS |

## Verification
A wrong internal state shows up first at the CAN-side outputs. A sleep state entered too early drops can_clk_en, and raises tx_pin and both inhibits, on the CAN edge after the offending input. A state stuck in draining leaves sleep_ack at 0 well past the ten-cycle bound. Faults in the reception hold are found by dropping rx_busy before any bus_idle pulse and by checking that the block stays awake. Faults in the recovery counter show in busoff_runs on the CAN edge after each run11 pulse.

// File: rtl/can_sleep_pkg.sv
package can_sleep_pkg;
   typedef enum logic [1:0] {
      PS_AWAKE = 2'd0,
      PS_DRAIN = 2'd1,
      PS_SLEEP = 2'd2
   } psleep_t;
endpackage

// File: rtl/csc_sync.sv
module csc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("csc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/csc_fsm.sv
module csc_fsm
   import can_sleep_pkg::*;
#(
   parameter int NUM_TXB = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_s,
   input  logic [NUM_TXB-1:0] txe,
   input  logic               tx_busy,
   input  logic               rx_busy,
   input  logic               bus_idle,
   output logic               asleep
);
   psleep_t state, state_nxt;
   logic    rx_wait, rx_wait_nxt;
   logic    tx_done, rx_hold;

   assign tx_done = (&txe) && !tx_busy;
   // a reception seen during the request is released only by bus idle
   assign rx_hold = rx_busy || (rx_wait && !bus_idle);

   always_comb begin
      state_nxt   = state;
      rx_wait_nxt = 1'b0;
      unique case (state)
         PS_AWAKE: begin
            if (req_s) begin
               if (tx_done && !rx_busy) begin
                  state_nxt = PS_SLEEP;
               end else begin
                  state_nxt   = PS_DRAIN;
                  rx_wait_nxt = rx_busy;
               end
            end
         end
         PS_DRAIN: begin
            if (!req_s) begin
               state_nxt = PS_AWAKE;
            end else if (tx_done && !rx_hold) begin
               state_nxt = PS_SLEEP;
            end else begin
               rx_wait_nxt = bus_idle ? 1'b0 : (rx_wait || rx_busy);
            end
         end
         PS_SLEEP: begin
            if (!req_s) state_nxt = PS_AWAKE;
         end
         default: state_nxt = PS_AWAKE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= PS_AWAKE;
         rx_wait <= 1'b0;
      end else begin
         state   <= state_nxt;
         rx_wait <= rx_wait_nxt;
      end
   end

   assign asleep = (state == PS_SLEEP);
endmodule

// File: rtl/csc_busoff_cnt.sv
module csc_busoff_cnt #(
   parameter int RECOV_RUNS = 128,
   localparam int CNT_W = $clog2(RECOV_RUNS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_off,
   input  logic             run11,
   input  logic             hold,
   output logic [CNT_W-1:0] runs,
   output logic             done
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RECOV_RUNS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              runs <= '0;
      else if (hold)           runs <= runs;
      else if (!bus_off)       runs <= '0;
      else if (run11 && !done) runs <= runs + 1'b1;
   end

   assign done = (runs == LIMIT);
endmodule

// File: rtl/can_sleep_ctrl.sv
module can_sleep_ctrl #(
   parameter int NUM_TXB     = 3,
   parameter int SYNC_STAGES = 2,
   parameter int RECOV_RUNS  = 128,
   localparam int CNT_W = $clog2(RECOV_RUNS + 1)
) (
   input  logic               bus_clk,
   input  logic               can_clk,
   input  logic               rst_n,
   input  logic               sleep_req,
   output logic               sleep_ack,
   input  logic [NUM_TXB-1:0] txe,
   input  logic               tx_busy,
   input  logic               rx_busy,
   input  logic               bus_idle,
   input  logic               bus_off,
   input  logic               run11,
   input  logic               tx_core,
   output logic               tx_pin,
   output logic               can_clk_en,
   output logic               rx_shift_inhibit,
   output logic               abort_inhibit,
   output logic [CNT_W-1:0]   busoff_runs,
   output logic               busoff_done
);
   generate
      if (NUM_TXB < 1) begin : g_bad_txb
         $error("can_sleep_ctrl: NUM_TXB must be at least 1");
      end
      if (RECOV_RUNS < 1) begin : g_bad_runs
         $error("can_sleep_ctrl: RECOV_RUNS must be at least 1");
      end
   endgenerate

   logic req_can;
   logic asleep;

   csc_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
      .clk(can_clk), .rst_n(rst_n), .d(sleep_req), .q(req_can)
   );

   csc_fsm #(.NUM_TXB(NUM_TXB)) i_fsm (
      .clk(can_clk), .rst_n(rst_n), .req_s(req_can), .txe(txe),
      .tx_busy(tx_busy), .rx_busy(rx_busy), .bus_idle(bus_idle),
      .asleep(asleep)
   );

   csc_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
      .clk(bus_clk), .rst_n(rst_n), .d(asleep), .q(sleep_ack)
   );

   csc_busoff_cnt #(.RECOV_RUNS(RECOV_RUNS)) i_cnt (
      .clk(can_clk), .rst_n(rst_n), .bus_off(bus_off), .run11(run11),
      .hold(asleep), .runs(busoff_runs), .done(busoff_done)
   );

   assign can_clk_en       = !asleep;
   assign tx_pin           = asleep ? 1'b1 : tx_core;
   assign rx_shift_inhibit = asleep;
   assign abort_inhibit    = asleep;
endmodule

// File: rtl/can_sleep_ctrl_chk.sv
module can_sleep_ctrl_chk #(
   parameter int NUM_TXB    = 3,
   parameter int RECOV_RUNS = 128,
   localparam int CNT_W = $clog2(RECOV_RUNS + 1)
) (
   input logic               can_clk,
   input logic               rst_n,
   input logic [NUM_TXB-1:0] txe,
   input logic               tx_busy,
   input logic               rx_busy,
   input logic               tx_pin,
   input logic               can_clk_en,
   input logic               rx_shift_inhibit,
   input logic               abort_inhibit,
   input logic [CNT_W-1:0]   busoff_runs
);
   // R3
   sleep_needs_tx_empty_chk: assert property (@(posedge can_clk) disable iff (!rst_n)
      $fell(can_clk_en) |-> $past((&txe) && !tx_busy));

   // R4
   sleep_needs_rx_quiet_chk: assert property (@(posedge can_clk) disable iff (!rst_n)
      $fell(can_clk_en) |-> $past(!rx_busy));

   // R5
   sleep_outputs_chk: assert property (@(posedge can_clk) disable iff (!rst_n)
      !can_clk_en |-> (tx_pin && rx_shift_inhibit && abort_inhibit));

   // R6
   count_frozen_chk: assert property (@(posedge can_clk) disable iff (!rst_n)
      $past(!can_clk_en) |-> $stable(busoff_runs));

   // R6
   count_limit_chk: assert property (@(posedge can_clk) disable iff (!rst_n)
      busoff_runs <= CNT_W'(RECOV_RUNS));
endmodule

bind can_sleep_ctrl can_sleep_ctrl_chk #(.NUM_TXB(NUM_TXB), .RECOV_RUNS(RECOV_RUNS)) i_chk (
   .can_clk(can_clk), .rst_n(rst_n), .txe(txe), .tx_busy(tx_busy), .rx_busy(rx_busy),
   .tx_pin(tx_pin), .can_clk_en(can_clk_en), .rx_shift_inhibit(rx_shift_inhibit),
   .abort_inhibit(abort_inhibit), .busoff_runs(busoff_runs)
);

// File: tb/test_can_sleep_ctrl.sv
module test_can_sleep_ctrl;
   localparam int BUS_PERIOD = 10;
   localparam int CAN_PERIOD = 14;
   localparam int NTX   = 3;
   localparam int RUNS  = 128;
   localparam int CW    = $clog2(RUNS + 1);

   logic bus_clk = 0, can_clk = 0, rst_n = 0;
   logic sleep_req = 0, sleep_ack;
   logic [NTX-1:0] txe = '1;
   logic tx_busy = 0, rx_busy = 0, bus_idle = 0, bus_off = 0, run11 = 0, tx_core = 0;
   logic tx_pin, can_clk_en, rx_shift_inhibit, abort_inhibit, busoff_done;
   logic [CW-1:0] busoff_runs;
   int checks = 0, errors = 0;
   bit done_flag = 0;

   always #(BUS_PERIOD/2) bus_clk = ~bus_clk;
   always #(CAN_PERIOD/2) can_clk = ~can_clk;

   can_sleep_ctrl #(.NUM_TXB(NTX), .SYNC_STAGES(2), .RECOV_RUNS(RUNS)) i_can_sleep_ctrl (
      .bus_clk(bus_clk), .can_clk(can_clk), .rst_n(rst_n),
      .sleep_req(sleep_req), .sleep_ack(sleep_ack), .txe(txe),
      .tx_busy(tx_busy), .rx_busy(rx_busy), .bus_idle(bus_idle),
      .bus_off(bus_off), .run11(run11), .tx_core(tx_core), .tx_pin(tx_pin),
      .can_clk_en(can_clk_en), .rx_shift_inhibit(rx_shift_inhibit),
      .abort_inhibit(abort_inhibit), .busoff_runs(busoff_runs),
      .busoff_done(busoff_done)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   task automatic bus_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge bus_clk);
   endtask

   task automatic can_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge can_clk);
   endtask

   task automatic wait_ack(input logic val, input int limit, output int n);
      n = 0;
      while (sleep_ack !== val && n < limit) begin
         @(negedge bus_clk);
         n++;
      end
   endtask

   task automatic pulse_run11(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge can_clk); run11 = 1;
         @(negedge can_clk); run11 = 0;
      end
   endtask

   task automatic check_awake(input string req);
      check(req, sleep_ack, 0);
      check(req, can_clk_en, 1);
   endtask

   task automatic do_wake();
      int n;
      @(negedge bus_clk); sleep_req = 0;
      wait_ack(1'b0, 20, n);
      can_cycles(2);
      check("R7 wake ack", sleep_ack, 0);
      check("R7 wake clk_en", can_clk_en, 1);
   endtask

   initial begin
      #(BUS_PERIOD * 200000);
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      finish_run();
   end

   initial begin
      int n;
      bus_cycles(3);
      rst_n = 1;
      bus_cycles(2);
      // R1 reset state
      @(negedge can_clk);
      check("R1 ack", sleep_ack, 0);
      check("R1 clk_en", can_clk_en, 1);
      check("R1 rx inhibit", rx_shift_inhibit, 0);
      check("R1 abort inhibit", abort_inhibit, 0);
      check("R1 runs", busoff_runs, 0);
      tx_core = 0; #1; check("R1 tx_pin low", tx_pin, 0);
      tx_core = 1; #1; check("R1 tx_pin high", tx_pin, 1);

      // R2 idle entry with latency bound; R5 sleep outputs over both tx_core values
      @(negedge bus_clk); sleep_req = 1;
      wait_ack(1'b1, 40, n);
      check("R2 ack latency ok", (n >= 3 && n <= 10), 1);
      @(negedge can_clk);
      check("R2 clk_en", can_clk_en, 0);
      for (int v = 0; v < 2; v++) begin
         tx_core = v[0]; #1;
         check("R5 tx_pin recessive", tx_pin, 1);
         check("R5 rx inhibit", rx_shift_inhibit, 1);
         check("R5 abort inhibit", abort_inhibit, 1);
      end
      do_wake();
      tx_core = 0; #1; check("R7 tx_pin follows", tx_pin, 0);

      // R3 sweep: each single pending buffer, every pending pattern, and tx_busy
      for (int pat = 0; pat < (1 << NTX); pat++) begin
         for (int b = 0; b < 2; b++) begin
            if (pat == (1 << NTX) - 1 && b == 0) continue;
            @(negedge can_clk); txe = pat[NTX-1:0]; tx_busy = b[0];
            @(negedge bus_clk); sleep_req = 1;
            bus_cycles(25);
            check_awake($sformatf("R3 deferred pat=%0d busy=%0d", pat, b));
            @(negedge can_clk); txe = '1; tx_busy = 0;
            wait_ack(1'b1, 20, n);
            check($sformatf("R3 enter pat=%0d busy=%0d", pat, b), sleep_ack, 1);
            check("R3 clk_en", can_clk_en, 0);
            do_wake();
         end
      end

      // R4 reception: rx_busy falls, still waits for bus_idle
      @(negedge can_clk); rx_busy = 1;
      @(negedge bus_clk); sleep_req = 1;
      bus_cycles(20);
      check_awake("R4 receiving");
      @(negedge can_clk); rx_busy = 0;
      bus_cycles(20);
      check_awake("R4 no idle yet");
      @(negedge can_clk); bus_idle = 1;
      @(negedge can_clk); bus_idle = 0;
      check("R4 enter on idle", can_clk_en, 0);
      wait_ack(1'b1, 20, n);
      check("R4 ack", sleep_ack, 1);
      do_wake();

      // R4 with transmit pending too: idle alone is not enough
      @(negedge can_clk); rx_busy = 1; txe = 3'b101;
      @(negedge bus_clk); sleep_req = 1;
      bus_cycles(15);
      @(negedge can_clk); rx_busy = 0; bus_idle = 1;
      @(negedge can_clk); bus_idle = 0;
      bus_cycles(10);
      check_awake("R4 tx still pending");
      @(negedge can_clk); txe = '1;
      wait_ack(1'b1, 20, n);
      check("R4 enter after tx", sleep_ack, 1);
      do_wake();

      // R8 cancel while deferred
      @(negedge can_clk); txe = 3'b011;
      @(negedge bus_clk); sleep_req = 1;
      bus_cycles(15);
      @(negedge bus_clk); sleep_req = 0;
      bus_cycles(10);
      @(negedge can_clk); txe = '1;
      bus_cycles(20);
      check_awake("R8 cancelled");

      // R6 bus-off recovery counter
      @(negedge can_clk); bus_off = 1;
      pulse_run11(5);
      check("R6 count 5", busoff_runs, 5);
      @(negedge bus_clk); sleep_req = 1;
      wait_ack(1'b1, 20, n);
      pulse_run11(3);
      check("R6 held in sleep", busoff_runs, 5);
      @(negedge can_clk); bus_off = 0;
      can_cycles(3);
      check("R6 held clear in sleep", busoff_runs, 5);
      bus_off = 1;
      do_wake();
      pulse_run11(RUNS - 6);
      check("R6 below limit", busoff_runs, RUNS - 1);
      check("R6 not done", busoff_done, 0);
      pulse_run11(1);
      check("R6 at limit", busoff_runs, RUNS);
      check("R6 done", busoff_done, 1);
      pulse_run11(2);
      check("R6 saturates", busoff_runs, RUNS);
      @(negedge can_clk); bus_off = 0;
      @(negedge can_clk);
      check("R6 cleared", busoff_runs, 0);

      finish_run();
   end
endmodule